// File: doc/BRIEF.md
# Global-History Branch Direction and Target Predictor

This block sits beside the fetch stage and answers, in the same cycle, two questions about the instruction at the fetch address. The first is whether the branch will be taken. The second is where it goes. It keeps one table of saturating counters and one table of stored targets. Both tables are indexed by the low bits of the fetch address XORed with a global history of recent branch outcomes. The decoder may already know the branch displacement. When the fetch stage supplies that signed displacement and it is nonzero, the predicted target is the fetch address plus that displacement, and the stored target is not used. A displacement of zero means "not known", and the stored target is returned instead.

The prediction path is purely combinational. The block also returns the table index it used, so the fetch stage can carry that index down the pipeline. When the branch resolves, the execute stage sends an update with that same index, the actual direction and the actual target. On that clock edge the block moves the counter one step toward the outcome, overwrites the stored target and shifts the outcome into the history. A separate flush input clears the history when the front end is redirected, and leaves the tables alone.

Top module: `gshare_pred`

## Requirements
- R1: The returned index is `pred_pc[IDX_W-1:0]` XOR the history register, with the history zero-extended to `IDX_W` bits.
- R2: `pred_taken` is 1 exactly when the indexed counter has its top bit set, that is, when it is at or above half of its range.
- R3: When `pred_offset` is nonzero, `pred_target` equals `pred_pc` plus `pred_offset` sign-extended from `OFF_W` bits, modulo 2^`ADDR_W`. A negative offset therefore gives a target below the fetch address.
- R4: When `pred_offset` is zero, `pred_target` equals the target stored in the indexed entry.
- R5: An update with `upd_taken`=1 raises the counter at `upd_index` by one, and holds it at 2^`CNT_W`-1.
- R6: An update with `upd_taken`=0 lowers the counter at `upd_index` by one, and holds it at 0.
- R7: An update writes `upd_target` into the stored target at `upd_index`. From the next cycle on, that value is seen with a zero offset.
- R8: An update without a flush changes the history to ((history << 1) | `upd_taken`) masked to `HIST_W` bits. With neither an update nor a flush, the history holds its value.
- R9: `hist_flush` clears the history on the next edge, and takes priority over the shift from an update in the same cycle. A counter or target update in that cycle still takes effect.
- R10: While `rst_n` is low at a clock edge, every counter is set to the weakly not-taken value 2^(`CNT_W`-1)-1, every stored target is set to zero and the history is set to zero.
- R11: An update changes only the entry at `upd_index`. All other counters and stored targets keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| pred_pc | input | ADDR_W | Fetch address to predict for |
| pred_offset | input | OFF_W | Signed displacement known at decode; zero means unknown |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| pred_target | output | ADDR_W | Predicted target address |
| pred_index | output | IDX_W | Table index used; returned later with the update |
| upd_valid | input | 1 | Apply a resolved branch outcome this cycle |
| upd_index | input | IDX_W | Index captured at prediction time |
| upd_taken | input | 1 | Resolved direction |
| upd_target | input | ADDR_W | Resolved target address |
| hist_flush | input | 1 | Clear the global history |

## Verification
The bench builds the block with a 4-bit index, a 3-bit history, 2-bit counters, a 16-bit address and a 12-bit offset. With these values the whole 16-entry table can be read back through the prediction port after every update, by choosing the fetch address low bits as the wanted index XOR the modelled history. The 12-bit offset is narrower than the address, so the sign extension and the wrap-around at both ends of the address space can be reached with a few chosen values. A pseudo-random stream of several hundred updates and flushes is replayed against an arithmetic model of the counters, targets and history. Directed runs drive counters into both saturation limits.

// File: rtl/gshare_pkg.sv
// Shared helpers for the global-history predictor.
// Assumes: counter widths of at least 1 bit.
package gshare_pkg;

    // Saturation ceiling of an unsigned counter of the given width.
    function automatic int unsigned ctr_ceiling(input int unsigned width);
        return (1 << width) - 1;
    endfunction

    // Highest value that still predicts not-taken (weakly not-taken).
    function automatic int unsigned ctr_weak_nt(input int unsigned width);
        return (1 << (width - 1)) - 1;
    endfunction

endpackage

// File: rtl/gshare_ctr_step.sv
// Saturating up/down step for one direction counter.
// Assumes: a purely combinational use; the caller registers the result.
module gshare_ctr_step #(
    parameter int CNT_W = 2
) (
    input  logic [CNT_W-1:0] cur,
    input  logic             up,
    output logic [CNT_W-1:0] nxt
);
    localparam logic [CNT_W-1:0] CEIL = CNT_W'(gshare_pkg::ctr_ceiling(CNT_W));

    // Move one step toward the outcome, stopping at either end of the range.
    always_comb begin
        if (up) begin
            nxt = (cur == CEIL) ? cur : cur + CNT_W'(1);
        end else begin
            nxt = (cur == '0) ? cur : cur - CNT_W'(1);
        end
    end
endmodule

// File: rtl/gshare_hist.sv
// Global branch history shift register.
// Assumes: HIST_W >= 2; clear has priority over shift.
module gshare_hist #(
    parameter int HIST_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              shift_bit,
    input  logic              clear,
    output logic [HIST_W-1:0] hist_q
);
    // Reset, clear, or shift the newest outcome into bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (clear) begin
            hist_q <= '0;
        end else if (shift_en) begin
            hist_q <= {hist_q[HIST_W-2:0], shift_bit};
        end
    end

    // R9: a flush empties the history on the next edge
    a_r9_flush_clears: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (hist_q == '0));

    // R8: the outcome enters at bit 0 and older bits move up by one
    a_r8_shift_in: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !clear) |=>
            (hist_q[0] == $past(shift_bit)) &&
            (hist_q[HIST_W-1:1] == $past(hist_q[HIST_W-2:0])));

    // R8: with neither update nor flush the history holds
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_en && !clear) |=> $stable(hist_q));
endmodule

// File: rtl/gshare_table.sv
// Counter and target storage, one read port and one write port.
// Assumes: reads are combinational; writes land on the rising edge;
// reset initialises every entry, so it takes one cycle with rst_n low.
module gshare_table #(
    parameter int IDX_W  = 11,
    parameter int CNT_W  = 2,
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [CNT_W-1:0]  rd_cnt,
    output logic [ADDR_W-1:0] rd_tgt,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_taken,
    input  logic [ADDR_W-1:0] wr_tgt
);
    localparam int               ENTRIES = 1 << IDX_W;
    localparam logic [CNT_W-1:0] WEAK_NT = CNT_W'(gshare_pkg::ctr_weak_nt(CNT_W));
    localparam logic [CNT_W-1:0] CEIL    = CNT_W'(gshare_pkg::ctr_ceiling(CNT_W));

    logic [CNT_W-1:0]  cnt_q [ENTRIES];
    logic [ADDR_W-1:0] tgt_q [ENTRIES];
    logic [CNT_W-1:0]  cnt_next;

    // Next counter value for the entry being trained.
    gshare_ctr_step #(.CNT_W(CNT_W)) step_i (
        .cur (cnt_q[wr_idx]),
        .up  (wr_taken),
        .nxt (cnt_next)
    );

    // Prediction-side read of the indexed entry.
    always_comb begin
        rd_cnt = cnt_q[rd_idx];
        rd_tgt = tgt_q[rd_idx];
    end

    // Reset all entries, or train the one entry named by the update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int e = 0; e < ENTRIES; e++) begin
                cnt_q[e] <= WEAK_NT;
                tgt_q[e] <= '0;
            end
        end else if (wr_en) begin
            cnt_q[wr_idx] <= cnt_next;
            tgt_q[wr_idx] <= wr_tgt;
        end
    end

    // R5: a taken update on a full counter leaves it full
    a_r5_sat_top: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_taken && cnt_q[wr_idx] == CEIL) |=>
            (cnt_q[$past(wr_idx)] == CEIL));

    // R6: a not-taken update on an empty counter leaves it empty
    a_r6_sat_floor: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_taken && cnt_q[wr_idx] == '0) |=>
            (cnt_q[$past(wr_idx)] == '0));

    // R7: the resolved target is stored at the update index
    a_r7_target_write: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (tgt_q[$past(wr_idx)] == $past(wr_tgt)));
endmodule

// File: rtl/gshare_pred.sv
// Global-history direction and target predictor.
// Prediction is combinational from the fetch address, the decoded offset
// and the current history. Updates and flushes act on the rising edge.
// Assumes: HIST_W <= IDX_W <= ADDR_W; a zero offset means "not known".
module gshare_pred #(
    parameter int IDX_W  = 11,
    parameter int CNT_W  = 2,
    parameter int HIST_W = 10,
    parameter int ADDR_W = 64,
    parameter int OFF_W  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] pred_pc,
    input  logic [OFF_W-1:0]  pred_offset,
    output logic              pred_taken,
    output logic [ADDR_W-1:0] pred_target,
    output logic [IDX_W-1:0]  pred_index,
    input  logic              upd_valid,
    input  logic [IDX_W-1:0]  upd_index,
    input  logic              upd_taken,
    input  logic [ADDR_W-1:0] upd_target,
    input  logic              hist_flush
);
    logic [HIST_W-1:0] hist;
    logic [CNT_W-1:0]  sel_cnt;
    logic [ADDR_W-1:0] sel_tgt;
    logic [ADDR_W-1:0] off_ext;
    logic              off_known;

    // Global history: shifted by updates, emptied by flushes.
    gshare_hist #(.HIST_W(HIST_W)) hist_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (upd_valid),
        .shift_bit (upd_taken),
        .clear     (hist_flush),
        .hist_q    (hist)
    );

    // Counter and target storage.
    gshare_table #(.IDX_W(IDX_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) table_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (pred_index),
        .rd_cnt   (sel_cnt),
        .rd_tgt   (sel_tgt),
        .wr_en    (upd_valid),
        .wr_idx   (upd_index),
        .wr_taken (upd_taken),
        .wr_tgt   (upd_target)
    );

    // Hash the fetch address with the history to pick an entry.
    always_comb begin
        pred_index = pred_pc[IDX_W-1:0] ^ IDX_W'(hist);
    end

    // Direction from the counter top bit; target from offset or table.
    always_comb begin
        off_known   = |pred_offset;
        off_ext     = ADDR_W'($signed(pred_offset));
        pred_taken  = sel_cnt[CNT_W-1];
        pred_target = off_known ? (pred_pc + off_ext) : sel_tgt;
    end
endmodule

// File: tb/gshare_pred_tb_top.sv
// Self-checking bench on a small configuration with an arithmetic model.
module gshare_pred_tb_top;
    localparam int IW = 4;
    localparam int CW = 2;
    localparam int HW = 3;
    localparam int AW = 16;
    localparam int OW = 12;
    localparam int NE = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] pred_pc = '0;
    logic [OW-1:0] pred_offset = '0;
    logic          pred_taken;
    logic [AW-1:0] pred_target;
    logic [IW-1:0] pred_index;
    logic          upd_valid = 1'b0;
    logic [IW-1:0] upd_index = '0;
    logic          upd_taken = 1'b0;
    logic [AW-1:0] upd_target = '0;
    logic          hist_flush = 1'b0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit done = 0;

    int            cnt_m [NE];
    logic [AW-1:0] tgt_m [NE];
    int            hist_m;
    logic [15:0]   lfsr = 16'hACE1;

    gshare_pred #(.IDX_W(IW), .CNT_W(CW), .HIST_W(HW), .ADDR_W(AW), .OFF_W(OW)) dut_i (
        .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_offset(pred_offset),
        .pred_taken(pred_taken), .pred_target(pred_target), .pred_index(pred_index),
        .upd_valid(upd_valid), .upd_index(upd_index), .upd_taken(upd_taken),
        .upd_target(upd_target), .hist_flush(hist_flush)
    );

    always #2 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000 && !done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=<150000 cycles", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] lfsr_next(input logic [15:0] s);
        return s[0] ? ((s >> 1) ^ 16'hB400) : (s >> 1);
    endfunction

    // Apply one update/flush cycle and advance the model.
    task automatic step(input bit v, input int idx, input bit tk,
                        input logic [AW-1:0] tg, input bit fl);
        @(negedge clk);
        upd_valid = v; upd_index = IW'(idx); upd_taken = tk;
        upd_target = tg; hist_flush = fl;
        @(negedge clk);
        upd_valid = 1'b0; hist_flush = 1'b0;
        if (v) begin
            if (tk && cnt_m[idx] < 3) cnt_m[idx]++;
            if (!tk && cnt_m[idx] > 0) cnt_m[idx]--;
            tgt_m[idx] = tg;
        end
        if (fl) hist_m = 0;
        else if (v) hist_m = ((hist_m << 1) | int'(tk)) & 7;
    endtask

    // Read back every entry and the history through the prediction port.
    task automatic check_all(input string tag);
        for (int i = 0; i < NE; i++) begin
            @(negedge clk);
            pred_pc = {12'(16'h5A3 + i), 4'(i ^ hist_m)};
            pred_offset = '0;
            #1;
            chk(pred_index == IW'(i), {tag, " R1 index"}, int'(pred_index), i);
            chk(pred_taken == (cnt_m[i] >= 2), {tag, " R2 R5 R6 direction"},
                int'(pred_taken), int'(cnt_m[i] >= 2));
            chk(pred_target == tgt_m[i], {tag, " R4 R7 R11 stored target"},
                int'(pred_target), int'(tgt_m[i]));
        end
        @(negedge clk);
        pred_pc = 16'h1230;
        #1;
        chk(pred_index == IW'(hist_m), {tag, " R8 R9 history"}, int'(pred_index), hist_m);
    endtask

    // R3: nonzero offset gives pc plus sign-extended offset, wrapping.
    task automatic check_off(input logic [AW-1:0] pc, input logic [OW-1:0] off);
        int o;
        logic [AW-1:0] exp;
        o = int'(off);
        if (off[OW-1]) o = o - (1 << OW);
        exp = AW'(int'(pc) + o);
        @(negedge clk);
        pred_pc = pc; pred_offset = off;
        #1;
        chk(pred_target == exp, "R3 offset target", int'(pred_target), int'(exp));
        pred_offset = '0;
    endtask

    initial begin
        for (int i = 0; i < NE; i++) begin
            cnt_m[i] = 1;
            tgt_m[i] = '0;
        end
        hist_m = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R10: reset state of every entry and of the history
        check_all("R10 reset");

        // R5: three takens then two not-takens leave counter 1 only if it saturated
        for (int k = 0; k < 3; k++) step(1, 3, 1, 16'h0400 + 16'(k), 0);
        step(1, 3, 0, 16'h0410, 0);
        step(1, 3, 0, 16'h0420, 0);
        check_all("R5 ceiling");
        // R6: three not-takens then two takens reach 2 only if it stopped at 0
        for (int k = 0; k < 3; k++) step(1, 9, 0, 16'hF000, 0);
        step(1, 9, 1, 16'hF100, 0);
        step(1, 9, 1, 16'hF200, 0);
        check_all("R6 floor");

        // R9: flush together with an update still trains the entry
        step(1, 12, 1, 16'hBEEF, 1);
        check_all("R9 flush with update");

        // R3: corner offsets including sign extension and wrap
        check_off(16'h0100, 12'h800);
        check_off(16'hFFFF, 12'h7FF);
        check_off(16'h8000, 12'hFFF);
        check_off(16'h0000, 12'hFFF);
        check_off(16'h1234, 12'h001);
        for (int k = 0; k < 48; k++) begin
            lfsr = lfsr_next(lfsr);
            check_off(lfsr, (lfsr[11:0] == 0) ? 12'h001 : (lfsr[11:0] ^ 12'h5C3));
        end

        // R8 R11: pseudo-random updates, idle cycles and flushes
        for (int k = 0; k < 300; k++) begin
            lfsr = lfsr_next(lfsr);
            step(lfsr[0] | lfsr[1], int'(lfsr[5:2]), lfsr[6],
                 lfsr ^ 16'h3C3C, lfsr[9:7] == 3'd0);
            check_all("R8 R11 random");
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule